// File: doc/BRIEF.md
# Quad Line Driver Protection Controller

This block decides, every clock cycle, whether each of four power line drivers is switched on. Software owns a per-line enable register and a single interrupt-enable bit, both loaded through plain write strobes. Two over-temperature detector levels arrive as synchronous inputs: a warning tier and a critical tier. A warning trips only the lines that are both on and flagging current overload; a critical level trips every line and raises a global hot flag.

A trip is remembered per line in a thermal-status vector whose bits read 1 when normal and 0 when tripped. A tripped line stays off even if its enable bit is still 1. The bit returns to normal only in a cycle where software holds that line's enable bit at 0 and the critical input is low. The active-low interrupt is combinational and unlatched: it is pulled low while the interrupt-enable bit is set and some line that is actually switched on reports current overload.

Each line is governed by a four-state machine. `LN_OFF` means disabled and normal, `LN_ON` means driving, `LN_TRIP` means tripped with enable still 1, and `LN_HOLD` means tripped with enable 0, waiting for the critical input to fall. The transitions are: OFF to ON (enable set, critical low); OFF to TRIP or HOLD (critical high, by enable); ON to TRIP or HOLD (critical high, or warning with overload, by enable); ON to OFF (enable cleared); TRIP to OFF (enable cleared, critical low); TRIP to HOLD (enable cleared, critical high); HOLD to OFF (critical low, enable still 0); HOLD to TRIP (enable set again).

Top module: `line_guard`

## Requirements
- R1: While and after reset, all drivers are off (`drv_on` = 0), every thermal bit reads normal (`therm_ok` = all 1), `hot_flag` = 0 and `irq_n` = 1. The enable register and the interrupt-enable bit reset to 0.
- R2: Bit i of `drv_on` is 1 exactly when line i's enable bit is 1 and its thermal bit is 1. An enable write presented with `en_wr` = 1 takes effect at that clock edge, so the drivers follow at the same edge.
- R3: At an edge where `temp_warn` = 1 and `temp_crit` = 0, each line that is on and has `ovl_flag[i]` = 1 trips: `therm_ok[i]` becomes 0 and `drv_on[i]` becomes 0. Every other line keeps its state.
- R4: At an edge where `temp_crit` = 1, every `therm_ok` bit becomes 0, every driver turns off, and `hot_flag` becomes 1.
- R5: A tripped thermal bit returns to 1 only at an edge where that line's enable bit, after any write at that edge, is 0 and `temp_crit` is 0. While the enable bit stays 1, the bit stays 0 even after both temperature inputs drop.
- R6: While `temp_crit` is 1, no thermal bit can be restored. `hot_flag` equals the value `temp_crit` had at the previous edge, so it clears by itself once the input drops.
- R7: `irq_n` is combinational and low exactly when the interrupt-enable bit is 1 and some line has both `ovl_flag[i]` = 1 and `drv_on[i]` = 1. It goes high again as soon as those overload flags drop.
- R8: An overloading line that is switched off, by a thermal trip or by software clearing its enable bit, no longer holds `irq_n` low.
- R9: `sw_state` equals `drv_on` in every cycle, with bit i for line i.
- R10: A write with `ie_wr` = 1 loads `ie_wdata` into the interrupt-enable bit at that edge. While the bit is 0, `irq_n` stays 1 whatever the overload flags do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the line enable register |
| en_wdata | input | NUM_LINES | New enable bits, bit i for line i |
| ie_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ie_wdata | input | 1 | New interrupt-enable value |
| ovl_flag | input | NUM_LINES | Live current-overload flags per line |
| temp_warn | input | 1 | Warning-tier over-temperature level |
| temp_crit | input | 1 | Critical-tier over-temperature level |
| drv_on | output | NUM_LINES | Driver switch commands, 1 = on |
| sw_state | output | NUM_LINES | Readable switch-state vector |
| therm_ok | output | NUM_LINES | Latched thermal status, 1 = normal, 0 = tripped |
| hot_flag | output | 1 | Global critical-temperature flag |
| irq_n | output | 1 | Interrupt, active low, unlatched |

## Verification
The assertions assume that every input is a synchronous level, sampled only at rising edges, and that reset is held high from time zero for at least one edge. The overload flags and temperature levels are taken as arbitrary: they may change in any cycle and in any combination, including a warning and a critical level together or an enable write in the same cycle as a trip. The stimulus changes inputs only on falling edges and keeps the temperature inputs rare enough that lines spend long stretches on, tripped and held. Directed sequences force the restore-while-critical and the interrupt-release orderings.

// File: rtl/lg_pkg.sv
package lg_pkg;

    // Per-line control state.
    typedef enum logic [1:0] {
        LN_OFF  = 2'd0,   // enable 0, thermal normal
        LN_ON   = 2'd1,   // enable 1, thermal normal, driving
        LN_TRIP = 2'd2,   // thermal tripped, enable still 1
        LN_HOLD = 2'd3    // thermal tripped, enable 0, waiting for critical to fall
    } line_state_e;

endpackage

// File: rtl/lg_ctl_regs.sv
module lg_ctl_regs #(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 ie_wr,
    input  logic                 ie_wdata,
    output logic [NUM_LINES-1:0] en_next,
    output logic [NUM_LINES-1:0] en_q,
    output logic                 ie_q
);

    // Value the enable register holds after this edge; the line
    // machines look at it so a write acts at the edge it is taken.
    always_comb begin
        en_next = en_wr ? en_wdata : en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            ie_q <= 1'b0;
        end else begin
            en_q <= en_next;
            if (ie_wr) begin
                ie_q <= ie_wdata;
            end
        end
    end

endmodule

// File: rtl/lg_line_fsm.sv
module lg_line_fsm
    import lg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,        // enable bit after this edge
    input  logic ovl,       // live current-overload flag
    input  logic warn,      // warning-tier temperature
    input  logic crit,      // critical-tier temperature
    output logic drv,       // driver switch command
    output logic tor_ok     // thermal status, 1 = normal
);

    line_state_e state_q;
    line_state_e state_d;
    logic        trip;

    // Trip condition as seen from a driving line.
    always_comb begin
        trip = crit | (warn & ovl);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF: begin
                if (crit) begin
                    state_d = en ? LN_TRIP : LN_HOLD;
                end else if (en) begin
                    state_d = LN_ON;
                end
            end
            LN_ON: begin
                if (trip) begin
                    state_d = en ? LN_TRIP : LN_HOLD;
                end else if (!en) begin
                    state_d = LN_OFF;
                end
            end
            LN_TRIP: begin
                if (!en) begin
                    state_d = crit ? LN_HOLD : LN_OFF;
                end
            end
            LN_HOLD: begin
                if (en) begin
                    state_d = LN_TRIP;
                end else if (!crit) begin
                    state_d = LN_OFF;
                end
            end
            default: state_d = LN_OFF;
        endcase
    end

    // Output decode.
    always_comb begin
        drv    = 1'b0;
        tor_ok = 1'b0;
        unique case (state_q)
            LN_OFF:  tor_ok = 1'b1;
            LN_ON: begin
                drv    = 1'b1;
                tor_ok = 1'b1;
            end
            LN_TRIP: tor_ok = 1'b0;
            LN_HOLD: tor_ok = 1'b0;
            default: tor_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/lg_irq.sv
module lg_irq #(
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_LINES-1:0] ovl,
    input  logic [NUM_LINES-1:0] drv,
    input  logic                 ie,
    output logic                 irq_n
);

    logic [NUM_LINES-1:0] live;

    // Only lines that are actually switched on may raise the interrupt.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_gate
        assign live[g] = ovl[g] & drv[g];
    end

    always_comb begin
        irq_n = ~(ie & (|live));
    end

endmodule

// File: rtl/line_guard.sv
module line_guard #(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 ie_wr,
    input  logic                 ie_wdata,
    input  logic [NUM_LINES-1:0] ovl_flag,
    input  logic                 temp_warn,
    input  logic                 temp_crit,
    output logic [NUM_LINES-1:0] drv_on,
    output logic [NUM_LINES-1:0] sw_state,
    output logic [NUM_LINES-1:0] therm_ok,
    output logic                 hot_flag,
    output logic                 irq_n
);

    logic [NUM_LINES-1:0] en_next;
    logic [NUM_LINES-1:0] en_q;
    logic                 ie_q;

    lg_ctl_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .ie_wr    (ie_wr),
        .ie_wdata (ie_wdata),
        .en_next  (en_next),
        .en_q     (en_q),
        .ie_q     (ie_q)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lg_line_fsm u_fsm (
            .clk    (clk),
            .rst    (rst),
            .en     (en_next[g]),
            .ovl    (ovl_flag[g]),
            .warn   (temp_warn),
            .crit   (temp_crit),
            .drv    (drv_on[g]),
            .tor_ok (therm_ok[g])
        );
    end

    // Global critical flag follows the detector, one edge late.
    always_ff @(posedge clk) begin
        if (rst) begin
            hot_flag <= 1'b0;
        end else begin
            hot_flag <= temp_crit;
        end
    end

    assign sw_state = drv_on;

    lg_irq #(.NUM_LINES(NUM_LINES)) u_irq (
        .ovl   (ovl_flag),
        .drv   (drv_on),
        .ie    (ie_q),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/line_guard_chk.sv
module line_guard_chk #(
    parameter int NUM_LINES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] ovl_flag,
    input logic                 temp_warn,
    input logic                 temp_crit,
    input logic [NUM_LINES-1:0] drv_on,
    input logic [NUM_LINES-1:0] therm_ok,
    input logic                 hot_flag,
    input logic                 irq_n,
    input logic [NUM_LINES-1:0] en_q,
    input logic                 ie_q
);

    // R1: reset leaves drivers off and thermal bits normal
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (drv_on == '0 && therm_ok == '1 && !hot_flag && irq_n));

    // R2: a driver is on only with its enable and thermal bits set
    assert_drv_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (drv_on & ~(en_q & therm_ok)) == '0);

    // R3: warning trips exactly the overloaded driving lines
    assert_warn_trip_R3: assert property (@(posedge clk) disable iff (rst)
        (temp_warn && !temp_crit && (ovl_flag & drv_on) != '0)
        |=> ((therm_ok & $past(ovl_flag & drv_on)) == '0));

    // R4: critical level trips everything
    assert_crit_all_R4: assert property (@(posedge clk) disable iff (rst)
        temp_crit |=> (therm_ok == '0 && drv_on == '0 && hot_flag));

    // R5: a thermal bit only recovers with its enable bit at 0
    assert_restore_off_R5: assert property (@(posedge clk) disable iff (rst)
        ((therm_ok & ~$past(therm_ok)) != '0)
        |-> ((therm_ok & ~$past(therm_ok) & en_q) == '0));

    // R6: no recovery while critical was high; flag clears by itself
    assert_restore_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        $past(temp_crit) |-> (therm_ok == '0));

    assert_hot_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !temp_crit |=> !hot_flag);

    // R7: enabled overload on a driving line pulls the interrupt low
    assert_irq_low_R7: assert property (@(posedge clk) disable iff (rst)
        (ie_q && (ovl_flag & drv_on) != '0) |-> !irq_n);

    // R8: with no driving line overloaded the interrupt is released
    assert_irq_release_R8: assert property (@(posedge clk) disable iff (rst)
        ((ovl_flag & drv_on) == '0) |-> irq_n);

    // R10: masked interrupt never fires
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        !ie_q |-> irq_n);

endmodule

bind line_guard line_guard_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ovl_flag  (ovl_flag),
    .temp_warn (temp_warn),
    .temp_crit (temp_crit),
    .drv_on    (drv_on),
    .therm_ok  (therm_ok),
    .hot_flag  (hot_flag),
    .irq_n     (irq_n),
    .en_q      (en_q),
    .ie_q      (ie_q)
);

// File: tb/line_guard_bench.sv
module line_guard_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic         ie_wr = 1'b0;
    logic         ie_wdata = 1'b0;
    logic [N-1:0] ovl_flag = '0;
    logic         temp_warn = 1'b0;
    logic         temp_crit = 1'b0;
    logic [N-1:0] drv_on;
    logic [N-1:0] sw_state;
    logic [N-1:0] therm_ok;
    logic         hot_flag;
    logic         irq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference state, computed from the requirements.
    logic [N-1:0] m_en  = '0;
    logic [N-1:0] m_tok = '1;
    logic [N-1:0] m_drv = '0;
    logic         m_ie  = 1'b0;
    logic         m_hot = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    line_guard #(.NUM_LINES(N)) u_line_guard (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .ie_wr     (ie_wr),
        .ie_wdata  (ie_wdata),
        .ovl_flag  (ovl_flag),
        .temp_warn (temp_warn),
        .temp_crit (temp_crit),
        .drv_on    (drv_on),
        .sw_state  (sw_state),
        .therm_ok  (therm_ok),
        .hot_flag  (hot_flag),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected interrupt level from the current reference state.
    function automatic logic exp_irq(input logic ie, input logic [N-1:0] ov, input logic [N-1:0] drv);
        return ~(ie & (|(ov & drv)));
    endfunction

    // Thermal bits after one edge.
    function automatic logic [N-1:0] next_tok(input logic [N-1:0] tok, input logic [N-1:0] en_n,
                                              input logic [N-1:0] drv, input logic [N-1:0] ov,
                                              input logic wn, input logic cr);
        logic [N-1:0] trip;
        trip = cr ? '1 : (wn ? (ov & drv) : '0);
        return (tok & ~trip) | (~tok & ~en_n & {N{~cr}});
    endfunction

    // One clock cycle: apply inputs, check the interrupt, step the model, check state.
    task automatic cycle(input logic ew, input logic [N-1:0] ed, input logic iw, input logic id,
                         input logic [N-1:0] ov, input logic wn, input logic cr, input string tag);
        logic [N-1:0] en_n;
        logic [N-1:0] tok_n;
        @(negedge clk);
        en_wr = ew; en_wdata = ed; ie_wr = iw; ie_wdata = id;
        ovl_flag = ov; temp_warn = wn; temp_crit = cr;
        #1;
        check({"R7 irq ", tag}, {7'd0, irq_n}, {7'd0, exp_irq(m_ie, ov, m_drv)});
        en_n  = ew ? ed : m_en;
        tok_n = next_tok(m_tok, en_n, m_drv, ov, wn, cr);
        @(posedge clk);
        #1;
        m_en  = en_n;
        m_tok = tok_n;
        m_drv = en_n & tok_n;
        m_ie  = iw ? id : m_ie;
        m_hot = cr;
        check({"R2 drv ", tag}, {4'd0, drv_on}, {4'd0, m_drv});
        check({"R9 sw ", tag}, {4'd0, sw_state}, {4'd0, m_drv});
        check({"R5 tok ", tag}, {4'd0, therm_ok}, {4'd0, m_tok});
        check({"R6 hot ", tag}, {7'd0, hot_flag}, {7'd0, m_hot});
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 drv", {4'd0, drv_on}, 8'h00);
        check("R1 tok", {4'd0, therm_ok}, 8'h0f);
        check("R1 hot", {7'd0, hot_flag}, 8'h00);
        check("R1 irq", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        rst = 1'b0;

        // R10: overload with interrupt masked
        cycle(1'b1, 4'hf, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R2 enable all");
        check("R2 drv all on", {4'd0, drv_on}, 8'h0f);
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0, "R10 masked");
        check("R10 irq masked", {7'd0, irq_n}, 8'h01);
        cycle(1'b0, 4'h0, 1'b1, 1'b1, 4'h5, 1'b0, 1'b0, "R10 ie write");
        #1;
        check("R7 irq low", {7'd0, irq_n}, 8'h00);

        // R3: warning trips lines 0 and 2 only
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h5, 1'b1, 1'b0, "R3 warn");
        check("R3 tok", {4'd0, therm_ok}, 8'h0a);
        check("R3 drv", {4'd0, drv_on}, 8'h0a);
        check("R8 irq released by trip", {7'd0, irq_n}, 8'h01);

        // R5: bits stay tripped while enable remains 1
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R5 hold en");
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R5 hold en");
        check("R5 still tripped", {4'd0, therm_ok}, 8'h0a);
        cycle(1'b1, 4'ha, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R5 restore");
        check("R5 restored", {4'd0, therm_ok}, 8'h0f);
        cycle(1'b1, 4'hf, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R2 reenable");
        check("R2 drv reenabled", {4'd0, drv_on}, 8'h0f);

        // R4 / R6: critical trip, restore blocked while critical
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, "R4 crit");
        check("R4 tok", {4'd0, therm_ok}, 8'h00);
        check("R4 hot", {7'd0, hot_flag}, 8'h01);
        cycle(1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, "R6 blocked");
        check("R6 still tripped", {4'd0, therm_ok}, 8'h00);
        cycle(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R6 crit drop");
        check("R6 hot cleared", {7'd0, hot_flag}, 8'h00);
        check("R6 restored", {4'd0, therm_ok}, 8'h0f);

        // R8: software off releases the interrupt
        cycle(1'b1, 4'h2, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, "R8 on");
        #1;
        check("R7 irq line1", {7'd0, irq_n}, 8'h00);
        cycle(1'b1, 4'h0, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, "R8 sw off");
        #1;
        check("R8 irq released by sw", {7'd0, irq_n}, 8'h01);

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            logic ew, iw, id, wn, cr;
            logic [N-1:0] ed, ov;
            ew = ($urandom_range(3) == 0);
            ed = N'($urandom);
            iw = ($urandom_range(15) == 0);
            id = ($urandom_range(3) != 0);
            ov = N'($urandom) & N'($urandom);
            wn = ($urandom_range(7) == 0);
            cr = ($urandom_range(23) == 0);
            cycle(ew, ed, iw, id, ov, wn, cr, "rand R3 R4 R8 R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule